// File: doc/BRIEF.md
# Multi-channel edge timestamp capture

This block stamps the rising edges of up to eight slow, asynchronous clock inputs against one shared free-running counter. The counter runs in Gray code, so exactly one of its bits changes on each reference clock. Each input is brought into the reference clock domain and watched for a low-to-high change. When an enabled channel rises, the block copies the current count into that channel's holding register and raises the channel's "data present" flag. Every cycle of every input is captured, with none skipped.

A host polls the block through a small registered read port. It first reads the flag word to find out which channels hold fresh stamps. It then reads each such channel's stamp in three pieces: a low byte, a middle byte and a top nibble. Reading the low byte consumes the stamp and clears the flag. It also freezes the upper bits of the stamp, so the three pieces of one stamp always belong together. A sticky overrun bit per channel shows that an edge replaced a stamp that the host had not yet read.

Top module: `edge_stamp_capture`

## Requirements
- R1: While `rst_n` is low, `count_gray` and `rd_data` are 0. After reset every flag bit, every overrun bit and every stored stamp reads 0.
- R2: `count_gray` equals n XOR (n >> 1) modulo 2^20, where n is the number of clock edges since reset was released. Exactly one bit of it changes per clock.
- R3: Suppose `chan_in[k]` goes high between clock edges P0 and P1. The stamp stored for channel k is then the `count_gray` value present just after edge P2, which is two edges of synchronizer delay.
- R4: A stored stamp sets bit k of the flag word, which is read at address 0x00.
- R5: The read port is registered. A read with `rd_en` high at one edge presents its data on `rd_data` after that edge. A read of address 0x80+4k returns stamp bits [7:0] of channel k and clears flag bit k and overrun bit k.
- R6: Address 0x81+4k returns stamp bits [15:8] and address 0x82+4k returns {4'b0, bits [19:16]}. Both come from a copy taken at the last low-byte read of that channel, and later captures do not change them.
- R7: An edge on channel k while flag bit k is set overwrites the stamp and sets overrun bit k. The overrun word is read at address 0x01.
- R8: If an edge is taken in the same cycle as the low-byte read of that channel, the read returns the old byte. The flag stays set, the register takes the new stamp, and the overrun bit is not set.
- R9: While `chan_en[k]` is 0, edges on channel k leave its flag, its overrun bit and its stamp unchanged.
- R10: Address offset 3 inside a channel's window, and every address outside 0x00, 0x01 and the channel windows, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_in | input | 8 | Asynchronous inputs to be stamped |
| chan_en | input | 8 | Per-channel capture enable |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| count_gray | output | 20 | Shared Gray-coded counter |

## Verification
The bench drives one edge exactly two cycles before a low-byte read of the same channel. A design that gives priority to the clear would lose that stamp, and one that checks the flag too early would report a false overrun. It captures a second stamp between the low-byte read and the upper-byte reads of a first stamp, more than 256 cycles apart. Without the frozen copy, the upper bytes would come from the wrong stamp. It also stamps two channels in the same cycle, pulses a disabled channel, and forces an overrun. A wrong synchronizer depth shows up as a stamp that is off by one count.

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
  parameter int NCH = 8,
  parameter int CW  = 20,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] chan_in,
  input  logic [NCH-1:0] chan_en,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count_gray
);
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int UPW = CW - 8;

  logic [CW-1:0]  bin_q;
  logic [CW-1:0]  bin_nxt;
  logic [NCH-1:0] sync1, sync2, sync3;
  logic [NCH-1:0] rise, take, clr;
  logic [NCH-1:0] flags, ovr;
  logic [CW-1:0]  hold   [NCH];
  logic [UPW-1:0] shadow [NCH];
  logic           chan_hit;
  logic [CHB-1:0] ch_sel;
  logic [1:0]     part;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bin_q      <= '0;
      count_gray <= '0;
    end else begin
      bin_q      <= bin_nxt;
      count_gray <= bin_nxt ^ (bin_nxt >> 1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= chan_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end

  assign rise = sync2 & ~sync3;
  assign take = rise & chan_en;

  assign chan_hit = rd_addr[AW-1] && (rd_addr[AW-2:CHB+2] == '0);
  assign ch_sel   = rd_addr[CHB+1:2];
  assign part     = rd_addr[1:0];

  always_comb begin
    clr = '0;
    if (rd_en && chan_hit && part == 2'd0) clr[ch_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      ovr   <= '0;
    end else begin
      flags <= take | (flags & ~clr);
      ovr   <= (take & flags & ~clr) | (ovr & ~clr);
    end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hold[i]   <= '0;
        shadow[i] <= '0;
      end else begin
        if (take[i]) hold[i] <= count_gray;
        if (clr[i])  shadow[i] <= hold[i][CW-1:8];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (chan_hit) begin
        case (part)
          2'd0:    rd_data <= hold[ch_sel][7:0];
          2'd1:    rd_data <= shadow[ch_sel][7:0];
          2'd2:    rd_data <= 8'(shadow[ch_sel][UPW-1:8]);
          default: rd_data <= '0;
        endcase
      end else if (rd_addr == AW'(0)) rd_data <= 8'(flags);
      else if (rd_addr == AW'(1))     rd_data <= 8'(ovr);
      else                            rd_data <= '0;
    end
endmodule

module edge_stamp_capture_chk #(
  parameter int NCH = 8,
  parameter int CW  = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  count_gray,
  input logic [NCH-1:0] take,
  input logic [NCH-1:0] clr,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] ovr,
  input logic [NCH-1:0] chan_en
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  // R2
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $countones(count_gray ^ $past(count_gray)) == 1);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take != '0 |=> ($past(take) & ~flags) == '0);

  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr & ~take) != '0 |=> ($past(clr & ~take) & (flags | ovr)) == '0);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & flags & ~clr) != '0 |=> ($past(take & flags & ~clr) & ~ovr) == '0);

  // R9
  dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (flags & ~$past(flags) & ~$past(chan_en)) == '0);
endmodule

bind edge_stamp_capture edge_stamp_capture_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_gray(count_gray), .take(take),
  .clr(clr), .flags(flags), .ovr(ovr), .chan_en(chan_en)
);

// File: tb/test_edge_stamp_capture.sv
`timescale 1ns/1ps
module test_edge_stamp_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chan_in = '0;
  logic [7:0]  chan_en = 8'hFF;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [19:0] count_gray;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] ncyc;

  edge_stamp_capture i_edge_stamp_capture (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .chan_en(chan_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .count_gray(count_gray)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;

  function automatic logic [19:0] gray(input logic [31:0] n);
    logic [19:0] b;
    b = n[19:0];
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_stamp(input int ch, output logic [19:0] s);
    logic [7:0] lo, mi, hi;
    rd(8'h80 + 8'(4*ch), lo);
    rd(8'h81 + 8'(4*ch), mi);
    rd(8'h82 + 8'(4*ch), hi);
    s = {hi[3:0], mi, lo};
  endtask

  task automatic pulse(input logic [7:0] mask, output logic [19:0] stamp);
    logic [31:0] n0;
    chan_in = chan_in | mask;
    n0 = ncyc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chan_in = chan_in & ~mask;
    stamp = gray(n0 + 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [19:0] s;
    chk("R1 count in reset", count_gray, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, d); chk("R1 flags after reset", d, 0);
    rd(8'h01, d); chk("R1 overrun after reset", d, 0);
    rd_stamp(6, s); chk("R1 stamp after reset", s, 0);
  endtask

  task automatic t_counter;
    for (int i = 0; i < 40; i++) begin
      chk("R2 gray count", count_gray, gray(ncyc));
      @(negedge clk);
    end
  endtask

  task automatic t_single;
    logic [19:0] st, s;
    logic [7:0] d;
    pulse(8'h01, st);
    rd(8'h00, d); chk("R4 flag word", d, 8'h01);
    rd_stamp(0, s); chk("R3 R5 R6 stamp ch0", s, st);
    rd(8'h00, d); chk("R5 flag cleared", d, 8'h00);
  endtask

  task automatic t_multi;
    logic [19:0] st, s;
    logic [7:0] d;
    pulse(8'h90, st);
    rd(8'h00, d); chk("R4 two flags", d, 8'h90);
    rd_stamp(4, s); chk("R3 stamp ch4", s, st);
    rd(8'h00, d); chk("R5 only ch4 cleared", d, 8'h80);
    rd_stamp(7, s); chk("R3 stamp ch7", s, st);
  endtask

  task automatic t_overrun;
    logic [19:0] a, b, s;
    logic [7:0] d;
    pulse(8'h04, a);
    pulse(8'h04, b);
    rd(8'h01, d); chk("R7 overrun bit", d, 8'h04);
    rd_stamp(2, s); chk("R7 newer stamp kept", s, b);
    rd(8'h01, d); chk("R5 overrun cleared", d, 8'h00);
  endtask

  task automatic t_shadow;
    logic [19:0] a, b;
    logic [7:0] lo, mi, hi;
    pulse(8'h08, a);
    rd(8'h8C, lo); chk("R5 low byte A", lo, {24'b0, a[7:0]});
    repeat (300) @(negedge clk);
    pulse(8'h08, b);
    rd(8'h8D, mi); chk("R6 mid frozen A", mi, {24'b0, a[15:8]});
    rd(8'h8E, hi); chk("R6 top frozen A", hi, {28'b0, a[19:16]});
    rd(8'h8C, lo); chk("R5 low byte B", lo, {24'b0, b[7:0]});
    rd(8'h8D, mi); chk("R6 mid B", mi, {24'b0, b[15:8]});
  endtask

  task automatic t_collide;
    logic [19:0] a, b, s;
    logic [31:0] n0;
    logic [7:0] d;
    pulse(8'h02, a);
    chan_in[1] = 1'b1;
    n0 = ncyc;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h84;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk("R8 read returns old byte", rd_data, {24'b0, a[7:0]});
    chan_in[1] = 1'b0;
    b = gray(n0 + 2);
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R8 flag stays set", d, 8'h02);
    rd(8'h01, d); chk("R8 no overrun", d, 8'h00);
    rd_stamp(1, s); chk("R8 new stamp", s, b);
  endtask

  task automatic t_disabled;
    logic [19:0] st, s;
    logic [7:0] d;
    chan_en = 8'hDF;
    pulse(8'h20, st);
    rd(8'h00, d); chk("R9 no flag", d, 8'h00);
    rd(8'h01, d); chk("R9 no overrun", d, 8'h00);
    rd_stamp(5, s); chk("R9 stamp untouched", s, 0);
    chan_en = 8'hFF;
    pulse(8'h20, st);
    rd(8'h00, d); chk("R9 enabled again", d, 8'h20);
    rd_stamp(5, s); chk("R3 stamp ch5", s, st);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    logic [19:0] st;
    pulse(8'h40, st);
    rd(8'h9B, d); chk("R10 offset 3", d, 0);
    rd(8'hA0, d); chk("R10 outside window", d, 0);
    rd(8'h05, d); chk("R10 low unmapped", d, 0);
    rd(8'h00, d); chk("R10 flag not cleared", d, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_counter;
    t_single;
    t_multi;
    t_overrun;
    t_shadow;
    t_collide;
    t_disabled;
    t_unmapped;
    t_counter;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule